// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit

This block is a purely combinational eight-bit arithmetic and logic unit for a small single-cycle processor datapath. It takes two eight-bit operands and a four-bit operation code and produces an eight-bit result within the same cycle. The operation code is decoded from the instruction opcode by the surrounding control logic.

The choice between a register value and an eight-bit immediate for the second operand is made outside the block. Register and immediate instruction forms therefore share one implementation per operation. The supported operations are:

- wrapping addition and subtraction;
- bitwise AND, OR and XOR;
- a bitwise inversion of the second operand;
- left and logical right shifts, with the shift amount taken from the low three bits of the second operand.

The block holds no state and has no clock or reset. Both data inputs and the operation code are plain level signals, so there is no flow control at its edge.

Top module: `alu8_core`

## Requirements
- R1: Operation code 0 (add) drives `res` with `opnd_a + opnd_b` modulo 256.
- R2: Operation code 1 (subtract) drives `res` with `opnd_a - opnd_b` modulo 256, i.e. first operand minus second.
- R3: Operation codes 2, 3 and 4 drive `res` with the bitwise AND, OR and XOR of the two operands respectively.
- R4: Operation code 5 (invert) drives `res` with the bitwise inverse of `opnd_b`; the value of `opnd_a` has no effect on the result.
- R5: Operation code 6 (shift left) drives `res` with `opnd_a` shifted left by `opnd_b[2:0]` places with zeros entering at bit 0; `opnd_b[7:3]` has no effect.
- R6: Operation code 7 (shift right) drives `res` with `opnd_a` shifted right by `opnd_b[2:0]` places with zeros entering at bit 7 (logical shift); `opnd_b[7:3]` has no effect.
- R7: Operation codes 8 through 15 behave exactly as add (code 0).
- R8: `res` is a combinational function of the present inputs: it reflects a change of any input in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand (register value or immediate, selected outside) |
| op_sel | input | 4 | Operation code (0 add, 1 sub, 2 and, 3 or, 4 xor, 5 invert, 6 shl, 7 shr, 8-15 add) |
| res | output | 8 | Result |

## Verification
The embedded assertions check several properties whenever the inputs settle:

- subtraction is undone by adding the second operand back, and addition is undone by subtracting it;
- a non-zero shift leaves the vacated end bit at zero, in both directions;
- the invert result always equals the inverse of the second operand;
- every unused operation code returns the wrapped sum.

The directed bench scenarios cover what these local properties cannot pin down:

- exact shift results for all eight amounts with the upper amount bits set;
- the invert result staying fixed while the first operand varies;
- wrap-around corner values such as 255 + 1 and 0 - 1;
- the same-cycle response of the output to input changes.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_INV = 4'd5,
    OP_SHL = 4'd6,
    OP_SHR = 4'd7
  } alu_op_e;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             do_sub,
  output logic [WIDTH-1:0] y
);

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] undo;

  // one adder: subtraction as a + ~b + 1
  always_comb begin
    b_eff = do_sub ? ~b : b;
    y     = a + b_eff + {{(WIDTH-1){1'b0}}, do_sub};
  end

  // reverse the operation and expect the first operand back
  always_comb begin
    undo = do_sub ? (y + b) : (y - b);
    if (do_sub) begin
      assert_sub_inverse_R2: assert (undo == a)
        else $error("subtract result not invertible");
    end else begin
      assert_add_inverse_R1: assert (undo == a)
        else $error("add result not invertible");
    end
  end

endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] y_and,
  output logic [WIDTH-1:0] y_or,
  output logic [WIDTH-1:0] y_xor,
  output logic [WIDTH-1:0] y_inv
);

  always_comb begin
    y_and = a & b;
    y_or  = a | b;
    y_xor = a ^ b;
    y_inv = ~b;
  end

endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter #(
  parameter int WIDTH = 8,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] a,
  input  logic [SHW-1:0]   shamt,
  output logic [WIDTH-1:0] y_left,
  output logic [WIDTH-1:0] y_right
);

  logic [WIDTH-1:0] lstg [SHW+1];
  logic [WIDTH-1:0] rstg [SHW+1];

  assign lstg[0] = a;
  assign rstg[0] = a;

  // log2 barrel stages, stage i moves by 2**i places
  for (genvar i = 0; i < SHW; i++) begin : g_stage
    assign lstg[i+1] = shamt[i] ? (lstg[i] << (1 << i)) : lstg[i];
    assign rstg[i+1] = shamt[i] ? (rstg[i] >> (1 << i)) : rstg[i];
  end

  assign y_left  = lstg[SHW];
  assign y_right = rstg[SHW];

  always_comb begin
    if (shamt != '0) begin
      assert_shl_zero_fill_R5: assert (y_left[0] == 1'b0)
        else $error("left shift did not fill with zero");
      assert_shr_zero_fill_R6: assert (y_right[WIDTH-1] == 1'b0)
        else $error("right shift did not fill with zero");
    end
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int OPW   = 4,
  localparam int SHW  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [OPW-1:0]   op_sel,
  output logic [WIDTH-1:0] res
);

  alu_op_e          op;
  logic [WIDTH-1:0] arith_y;
  logic [WIDTH-1:0] and_y, or_y, xor_y, inv_y;
  logic [WIDTH-1:0] shl_y, shr_y;

  assign op = alu_op_e'(op_sel);

  alu8_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a      (opnd_a),
    .b      (opnd_b),
    .do_sub (op == OP_SUB),
    .y      (arith_y)
  );

  alu8_bitwise #(.WIDTH(WIDTH)) u_bitwise (
    .a     (opnd_a),
    .b     (opnd_b),
    .y_and (and_y),
    .y_or  (or_y),
    .y_xor (xor_y),
    .y_inv (inv_y)
  );

  alu8_shifter #(.WIDTH(WIDTH)) u_shifter (
    .a       (opnd_a),
    .shamt   (opnd_b[SHW-1:0]),
    .y_left  (shl_y),
    .y_right (shr_y)
  );

  always_comb begin
    unique case (op)
      OP_SUB:  res = arith_y;
      OP_AND:  res = and_y;
      OP_OR:   res = or_y;
      OP_XOR:  res = xor_y;
      OP_INV:  res = inv_y;
      OP_SHL:  res = shl_y;
      OP_SHR:  res = shr_y;
      default: res = arith_y;
    endcase
  end

  always_comb begin
    if (op == OP_INV) begin
      assert_inv_ignores_a_R4: assert (res == ~opnd_b)
        else $error("invert result depends on first operand");
    end
    if (op_sel > OPW'(7)) begin
      assert_spare_code_adds_R7: assert (res == WIDTH'(opnd_a + opnd_b))
        else $error("spare operation code did not add");
    end
  end

endmodule

// File: tb/sim_alu8_core.sv
module sim_alu8_core;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] opnd_a = '0;
  logic [7:0] opnd_b = '0;
  logic [3:0] op_sel = '0;
  logic [7:0] res;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alu8_core u0 (
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .op_sel (op_sel),
    .res    (res)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s op=%0d a=%02h b=%02h actual=%02h expected=%02h",
               req, op_sel, opnd_a, opnd_b, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    op_sel = op;
    opnd_a = a;
    opnd_b = b;
    #1;
  endtask

  task automatic t_reset();
    apply(4'd0, 8'h00, 8'h00);
    check("R1 reset", res, 8'h00);
  endtask

  task automatic t_add();
    logic [7:0] av [5] = '{8'h00, 8'hFF, 8'h7F, 8'h80, 8'h3C};
    logic [7:0] bv [5] = '{8'h00, 8'h01, 8'h01, 8'h80, 8'hA5};
    for (int i = 0; i < 5; i++) begin
      apply(4'd0, av[i], bv[i]);
      check("R1", res, 8'((int'(av[i]) + int'(bv[i])) % 256));
    end
  endtask

  task automatic t_sub();
    logic [7:0] av [5] = '{8'h00, 8'h05, 8'h80, 8'hFF, 8'h10};
    logic [7:0] bv [5] = '{8'h01, 8'h03, 8'h01, 8'hFF, 8'h20};
    for (int i = 0; i < 5; i++) begin
      apply(4'd1, av[i], bv[i]);
      check("R2", res, 8'((int'(av[i]) - int'(bv[i]) + 256) % 256));
    end
  endtask

  task automatic t_logic();
    logic [7:0] av [3] = '{8'hF0, 8'hAA, 8'h0F};
    logic [7:0] bv [3] = '{8'h3C, 8'h55, 8'hFF};
    for (int i = 0; i < 3; i++) begin
      apply(4'd2, av[i], bv[i]); check("R3 and", res, av[i] & bv[i]);
      apply(4'd3, av[i], bv[i]); check("R3 or",  res, av[i] | bv[i]);
      apply(4'd4, av[i], bv[i]); check("R3 xor", res, av[i] ^ bv[i]);
    end
  endtask

  task automatic t_inv();
    logic [7:0] av [4] = '{8'h00, 8'hFF, 8'h5A, 8'h81};
    for (int i = 0; i < 4; i++) begin
      apply(4'd5, av[i], 8'h36);
      check("R4", res, 8'hC9);
    end
    apply(4'd5, 8'h12, 8'h00);
    check("R4", res, 8'hFF);
  endtask

  task automatic t_shl();
    for (int s = 0; s < 8; s++) begin
      apply(4'd6, 8'hB5, 8'(8'hF8 | s));
      check("R5", res, 8'((16'h00B5 << s) & 16'h00FF));
    end
  endtask

  task automatic t_shr();
    for (int s = 0; s < 8; s++) begin
      apply(4'd7, 8'hB5, 8'(8'h48 | s));
      check("R6", res, 8'(8'hB5 / (1 << s)));
    end
  endtask

  task automatic t_spare();
    for (int c = 8; c < 16; c++) begin
      apply(4'(c), 8'hF3, 8'h1D);
      check("R7", res, 8'h10);
    end
  endtask

  task automatic t_comb();
    apply(4'd0, 8'h01, 8'h02);
    check("R8", res, 8'h03);
    opnd_a = 8'h40;
    #0.5;
    check("R8", res, 8'h42);
    op_sel = 4'd4;
    #0.5;
    check("R8", res, 8'h42 ^ 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_inv();
    t_shl();
    t_shr();
    t_spare();
    t_comb();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule